// File: doc/BRIEF.md
# Bidirectional Parity Transceiver

An eight-bit bus transceiver that sits between two data ports, A and B, and carries a parity bit alongside the data. A direction input selects which port drives. In transmit, the value on A is copied to B and the block drives a parity bit computed from A. In receive, the value on B is copied to A. The parity pin then becomes an input, and the block reports on an active-low error flag whether B plus that parity bit has the chosen sense.

An active-low output enable releases every pad the block can drive. A sense input selects odd or even parity. Each pad is modelled as separate input, output and output-enable signals, so a surrounding pad ring can build the tri-state drivers and a bench can observe the released state directly. The block is purely combinational and holds no state.

Top module: `prt_transceiver`

## Requirements
- R1: With oe_n_i low and dir_tx_i high (transmit), b_out equals a_in bit for bit (no inversion), every bit of b_oe is 1 and every bit of a_oe is 0.
- R2: With oe_n_i low and dir_tx_i low (receive), a_out equals b_in bit for bit (no inversion), every bit of a_oe is 1 and every bit of b_oe is 0.
- R3: With oe_n_i high, a_oe, b_oe, par_oe and flag_oe are all 0, whatever dir_tx_i, odd_sel_i and the pad inputs are.
- R4: In transmit with oe_n_i low, par_oe is 1. par_out makes the count of ones in {a_in, par_out} odd when odd_sel_i is 1 and even when odd_sel_i is 0 (for example, even sense with five ones on a_in gives par_out = 1).
- R5: In receive with oe_n_i low, flag_oe is 1. flag_out is 1 when the count of ones in {b_in, par_in} matches the selected sense (odd for odd_sel_i = 1, even for 0), and 0 otherwise (for example, odd sense, par_in = 1 and three ones on b_in give flag_out = 0).
- R6: In transmit, flag_oe is 0. In receive, par_oe is 0.
- R7: The source port's partner input has no effect on the outputs. In transmit, changing b_in leaves b_out and par_out unchanged. In receive, changing a_in leaves a_out and flag_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_tx_i | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| oe_n_i | input | 1 | Active-low output enable for all pads |
| odd_sel_i | input | 1 | 1 = odd parity sense, 0 = even |
| a_in | input | WIDTH | A pad input values |
| a_out | output | WIDTH | A pad drive values |
| a_oe | output | WIDTH | A pad drive enables |
| b_in | input | WIDTH | B pad input values |
| b_out | output | WIDTH | B pad drive values |
| b_oe | output | WIDTH | B pad drive enables |
| par_in | input | 1 | Parity pad input value |
| par_out | output | 1 | Parity pad drive value |
| par_oe | output | 1 | Parity pad drive enable |
| flag_out | output | 1 | Error flag drive value (low = parity error) |
| flag_oe | output | 1 | Error flag drive enable |

## Verification
The bench builds the block at its default WIDTH of 8. At that width every data word can be swept in both directions, under both parity senses, with both enable levels and, in receive, with both parity-input levels. Every parity count from zero to eight ones is therefore reached, including the all-zero and all-one words. The non-source port is fed an unrelated pattern and then re-driven, so that any leak from it into the outputs shows up at the pads.

// File: rtl/prt_pkg.sv
package prt_pkg;

    typedef enum logic {
        XFER_RX = 1'b0,
        XFER_TX = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic val;
        logic en;
    } pin_drv_t;

    // Bit that completes a word of raw XOR x to the requested sense.
    function automatic logic fill_bit(input logic x, input logic odd);
        return x ^ odd;
    endfunction

    // 1 when a raw XOR over all bits (data plus parity) matches the sense.
    function automatic logic sense_ok(input logic x, input logic odd);
        return ~(x ^ odd);
    endfunction

endpackage

// File: rtl/prt_parity_tree.sv
module prt_parity_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             xor_o
);
    localparam int STAGES = WIDTH + 1;

    logic [STAGES-1:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign chain[i+1] = chain[i] ^ data_i[i];
    end

    assign xor_o = chain[STAGES-1];
endmodule

// File: rtl/prt_steer.sv
module prt_steer #(
    parameter int WIDTH = 8
) (
    input  prt_pkg::xfer_dir_e dir_i,
    input  logic               en_i,
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   b_in,
    output logic [WIDTH-1:0]   a_out,
    output logic [WIDTH-1:0]   a_oe,
    output logic [WIDTH-1:0]   b_out,
    output logic [WIDTH-1:0]   b_oe
);
    import prt_pkg::*;

    logic drive_a;
    logic drive_b;

    always_comb begin
        drive_a = en_i && (dir_i == XFER_RX);
        drive_b = en_i && (dir_i == XFER_TX);
    end

    assign a_out = b_in;
    assign b_out = a_in;
    assign a_oe  = {WIDTH{drive_a}};
    assign b_oe  = {WIDTH{drive_b}};
endmodule

// File: rtl/prt_side_pins.sv
module prt_side_pins (
    input  prt_pkg::xfer_dir_e dir_i,
    input  logic               en_i,
    input  logic               odd_i,
    input  logic               a_xor_i,
    input  logic               b_xor_i,
    input  logic               par_in,
    output prt_pkg::pin_drv_t  par_drv_o,
    output prt_pkg::pin_drv_t  flag_drv_o
);
    import prt_pkg::*;

    always_comb begin
        par_drv_o.val  = fill_bit(a_xor_i, odd_i);
        par_drv_o.en   = en_i && (dir_i == XFER_TX);
        flag_drv_o.val = sense_ok(b_xor_i ^ par_in, odd_i);
        flag_drv_o.en  = en_i && (dir_i == XFER_RX);
    end
endmodule

// File: rtl/prt_transceiver.sv
module prt_transceiver #(
    parameter int WIDTH = 8
) (
    input  logic             dir_tx_i,
    input  logic             oe_n_i,
    input  logic             odd_sel_i,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             flag_out,
    output logic             flag_oe
);
    import prt_pkg::*;

    xfer_dir_e dir;
    logic      en;
    logic      a_xor;
    logic      b_xor;
    pin_drv_t  par_drv;
    pin_drv_t  flag_drv;

    assign dir = dir_tx_i ? XFER_TX : XFER_RX;
    assign en  = ~oe_n_i;

    prt_parity_tree #(.WIDTH(WIDTH)) u_tree_a (.data_i(a_in), .xor_o(a_xor));
    prt_parity_tree #(.WIDTH(WIDTH)) u_tree_b (.data_i(b_in), .xor_o(b_xor));

    prt_steer #(.WIDTH(WIDTH)) u_steer (
        .dir_i (dir),
        .en_i  (en),
        .a_in  (a_in),
        .b_in  (b_in),
        .a_out (a_out),
        .a_oe  (a_oe),
        .b_out (b_out),
        .b_oe  (b_oe)
    );

    prt_side_pins u_side (
        .dir_i      (dir),
        .en_i       (en),
        .odd_i      (odd_sel_i),
        .a_xor_i    (a_xor),
        .b_xor_i    (b_xor),
        .par_in     (par_in),
        .par_drv_o  (par_drv),
        .flag_drv_o (flag_drv)
    );

    assign par_out  = par_drv.val;
    assign par_oe   = par_drv.en;
    assign flag_out = flag_drv.val;
    assign flag_oe  = flag_drv.en;
endmodule

// File: rtl/prt_transceiver_chk.sv
module prt_transceiver_chk #(
    parameter int WIDTH = 8
) (
    input logic             dir_tx_i,
    input logic             oe_n_i,
    input logic             odd_sel_i,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_oe,
    input logic             par_in,
    input logic             par_out,
    input logic             par_oe,
    input logic             flag_out,
    input logic             flag_oe
);
    logic tx_on;
    logic rx_on;

    assign tx_on = !oe_n_i && dir_tx_i;
    assign rx_on = !oe_n_i && !dir_tx_i;

    always_comb begin
        p_tx_copy_r1: assert (!tx_on || (b_out == a_in && &b_oe && a_oe == '0))
            else $error("R1 transmit steering wrong");
        p_rx_copy_r2: assert (!rx_on || (a_out == b_in && &a_oe && b_oe == '0))
            else $error("R2 receive steering wrong");
        p_all_off_r3: assert (!oe_n_i || (a_oe == '0 && b_oe == '0 && !par_oe && !flag_oe))
            else $error("R3 disabled pads still driven");
        p_gen_sense_r4: assert (!tx_on || (par_oe && ((^{a_in, par_out}) == odd_sel_i)))
            else $error("R4 generated parity wrong");
        p_chk_sense_r5: assert (!rx_on || (flag_oe && (flag_out == ((^{b_in, par_in}) == odd_sel_i))))
            else $error("R5 error flag wrong");
        p_role_swap_r6: assert ((dir_tx_i || !par_oe) && (!dir_tx_i || !flag_oe))
            else $error("R6 wrong side pin driven");
    end
endmodule

bind prt_transceiver prt_transceiver_chk #(.WIDTH(WIDTH)) u_chk (
    .dir_tx_i  (dir_tx_i),
    .oe_n_i    (oe_n_i),
    .odd_sel_i (odd_sel_i),
    .a_in      (a_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_in      (b_in),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .par_in    (par_in),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .flag_out  (flag_out),
    .flag_oe   (flag_oe)
);

// File: tb/prt_transceiver_bench.sv
module prt_transceiver_bench;
    localparam int W        = 8;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    always #(CLK_PER/2) clk = ~clk;

    logic         dir_tx_i, oe_n_i, odd_sel_i, par_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         par_out, par_oe, flag_out, flag_oe;

    int checks = 0;
    int errors = 0;

    prt_transceiver #(.WIDTH(W)) u_prt_transceiver (
        .dir_tx_i(dir_tx_i), .oe_n_i(oe_n_i), .odd_sel_i(odd_sel_i),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .flag_out(flag_out), .flag_oe(flag_oe)
    );

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    logic         exp_par, exp_flag;
    logic [W-1:0] keep_out;
    logic         keep_side;

    initial begin
        int cyc = 0;
        while (cyc < WD_LIMIT) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        dir_tx_i = 1'b1; oe_n_i = 1'b1; odd_sel_i = 1'b0;
        par_in = 1'b0; a_in = '0; b_in = '0;
        settle();
        // R3: released state before any traffic
        check("R3 idle", {a_oe, b_oe, par_oe, flag_oe}, '0);

        for (int oe = 0; oe < 2; oe++) begin
            for (int dr = 0; dr < 2; dr++) begin
                for (int od = 0; od < 2; od++) begin
                    for (int pv = 0; pv < 2; pv++) begin
                        for (int d = 0; d < 256; d++) begin
                            oe_n_i    = oe[0];
                            dir_tx_i  = dr[0];
                            odd_sel_i = od[0];
                            par_in    = pv[0];
                            if (dr == 1) begin
                                a_in = d[W-1:0];
                                b_in = d[W-1:0] ^ 8'h5A;
                            end else begin
                                b_in = d[W-1:0];
                                a_in = ~d[W-1:0];
                            end
                            settle();
                            if (oe == 1) begin
                                check("R3 disabled", {a_oe, b_oe, par_oe, flag_oe}, '0);
                            end else if (dr == 1) begin
                                exp_par = (od == 1) ? (ones(a_in) % 2 == 0) : (ones(a_in) % 2 == 1);
                                check("R1 b_out", b_out, a_in);
                                check("R1 oe", {b_oe, a_oe}, {{W{1'b1}}, {W{1'b0}}});
                                check("R4 par_out", {par_oe, par_out}, {1'b1, exp_par});
                                check("R6 flag_oe", flag_oe, 1'b0);
                                if (d[3:0] == 4'h0) begin
                                    keep_out = b_out; keep_side = par_out;
                                    b_in = ~b_in;
                                    settle();
                                    check("R7 tx b_in ignored", {b_out, par_out}, {keep_out, keep_side});
                                end
                            end else begin
                                exp_flag = (((ones(b_in) + pv) % 2) == od);
                                check("R2 a_out", a_out, b_in);
                                check("R2 oe", {a_oe, b_oe}, {{W{1'b1}}, {W{1'b0}}});
                                check("R5 flag", {flag_oe, flag_out}, {1'b1, exp_flag});
                                check("R6 par_oe", par_oe, 1'b0);
                                if (d[3:0] == 4'h0) begin
                                    keep_out = a_out; keep_side = flag_out;
                                    a_in = ~a_in;
                                    settle();
                                    check("R7 rx a_in ignored", {a_out, flag_out}, {keep_out, keep_side});
                                end
                            end
                        end
                    end
                end
            end
        end

        // R4 worked case: even sense, five ones on A
        oe_n_i = 1'b0; dir_tx_i = 1'b1; odd_sel_i = 1'b0; a_in = 8'b0001_1111;
        settle();
        check("R4 five ones even", par_out, 1'b1);
        // R5 worked case: odd sense, parity in high, three ones on B
        dir_tx_i = 1'b0; odd_sel_i = 1'b1; par_in = 1'b1; b_in = 8'b0000_0111;
        settle();
        check("R5 three ones odd", flag_out, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule